// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits behind the bit-level receiver of an I2C controller that runs as a slave. The receiver hands it each completed byte together with a strobe, and it raises a separate qualifier for the first byte after a START or repeated START. From those bytes it decides whether the controller is being addressed, so that the surrounding logic knows whether to acknowledge and join the transfer. Bit shifting, ACK driving and the data phase are handled elsewhere.

Both 7-bit and 10-bit slave addressing are supported, chosen by a mode input. In 10-bit mode the first byte is a header of the form `11110 A9 A8 R/W`, and the second byte carries A7..A0. A match in that mode is reported only once both bytes agree. If a general-call enable is set, an all-zero 7-bit address field is also accepted. The direction bit then tells a general call (bit 0 = 0, byte 0x00) from a START byte (bit 0 = 1, byte 0x01). The captured direction and the general-call and START-byte flags hold until the next first byte, and all of them clear while the controller is disabled.

Top module: `i2c_addr_recog`

## Requirements
- R1: On every enabled first-byte strobe, `rd_dir` takes bit 0 of that byte from the next cycle on (1 = the master reads from the slave).
- R2: `rd_dir`, `gcall` and `start_byte` change only on an enabled first-byte strobe. Strobes that are not first bytes leave them unchanged.
- R3: While `enable` is 0, `rd_dir`, `gcall`, `start_byte` and `match_pulse` read 0 from the next cycle on. Any pending 10-bit recognition is dropped.
- R4: In 7-bit mode, a first byte whose bits [7:1] equal `own_addr[6:0]` (non-zero) gives `match_pulse` = 1 in the cycle after the strobe.
- R5: In 7-bit mode, a first byte whose bits [7:1] differ from `own_addr[6:0]` and are not a recognized general call gives no pulse.
- R6: With `gc_en` = 1, first byte 0x00 sets `gcall` = 1 and `start_byte` = 0, and first byte 0x01 sets `start_byte` = 1 and `gcall` = 0. Both pulse `match_pulse`, in either addressing mode.
- R7: With `gc_en` = 0, an all-zero address field (0x00 or 0x01) gives no pulse and leaves both flags at 0, even when `own_addr[6:0]` is 0.
- R8: In 10-bit mode, a first byte with bits [7:3] = 11110 and bits [2:1] = `own_addr[9:8]` gives no pulse by itself. The next non-first strobe pulses only if its byte equals `own_addr[7:0]`.
- R9: In 10-bit mode, a mismatched header or a mismatched second byte causes all further non-first bytes to be ignored until the next first byte.
- R10: `match_pulse` lasts exactly one cycle, and only in the cycle after a byte strobe.
- R11: A first-byte strobe always restarts recognition, abandoning a 10-bit header still waiting for its second byte.
- R12: In 7-bit mode, non-first bytes never pulse, whatever their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; 0 clears all recognition state |
| byte_vld | input | 1 | One-cycle strobe: `byte_data` holds a received byte |
| first_byte | input | 1 | Qualifies the strobe as the first byte after START |
| byte_data | input | 8 | Received byte, MSB first as on the bus |
| own_addr | input | 10 | Programmed slave address (bits 6:0 used in 7-bit mode) |
| mode_10b | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| gc_en | input | 1 | Enables general call and START byte recognition |
| match_pulse | output | 1 | One-cycle pulse when the address phase is accepted |
| gcall | output | 1 | General call recognized in the last first byte |
| start_byte | output | 1 | START byte recognized in the last first byte |
| rd_dir | output | 1 | Direction bit of the last first byte |

## Verification
The hardest condition to reach from the ports is a 10-bit header that is still waiting for its low byte when something else intervenes: a new first byte, a disable, or a wrong low byte followed by the right one. The bench reaches it by sweeping all 256 first bytes, each followed by the correct low byte. It also sweeps all 256 low bytes behind a matching header. Directed sequences then interrupt a pending header with a restart, a general call and a disable cycle, and each is followed by a byte that would have matched.

// File: rtl/i2c_ar_pkg.sv
`timescale 1ns/1ps
package i2c_ar_pkg;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_WAIT_LO = 1'b1
    } ar_state_e;

    typedef struct packed {
        ar_state_e st;
        logic      match;
        logic      rd;
        logic      gc;
        logic      sb;
    } ar_regs_t;

endpackage

// File: rtl/i2c_ar_hdr_dec.sv
`timescale 1ns/1ps
// Decodes the first byte after START: 7-bit hit, 10-bit header hit,
// general call and START byte.
module i2c_ar_hdr_dec #(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10,
    parameter int PFX_W  = BYTE_W - 1 - (ADDR_W - BYTE_W),
    parameter logic [PFX_W-1:0] HDR_PFX = 5'b11110
) (
    input  logic [BYTE_W-1:0]        byte_i,
    input  logic [BYTE_W-2:0]        own7_i,
    input  logic [ADDR_W-BYTE_W-1:0] own_hi_i,
    input  logic                     mode_10b_i,
    input  logic                     gc_en_i,
    output logic                     hit7_o,
    output logic                     hdr10_o,
    output logic                     gc_hit_o,
    output logic                     sb_hit_o
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic [BYTE_W-2:0] field;
    logic              field_zero;
    logic              gc_any;

    always_comb begin
        field      = byte_i[BYTE_W-1:1];
        field_zero = (field == '0);
        gc_any     = gc_en_i && field_zero;
        gc_hit_o   = gc_any && !byte_i[0];
        sb_hit_o   = gc_any && byte_i[0];
        hit7_o     = !mode_10b_i && !field_zero && (field == own7_i);
        hdr10_o    = mode_10b_i
                     && (byte_i[BYTE_W-1 -: PFX_W] == HDR_PFX)
                     && (byte_i[HI_W:1] == own_hi_i);
    end

endmodule

// File: rtl/i2c_ar_lo_cmp.sv
`timescale 1ns/1ps
// Compares the second byte of a 10-bit address with the low address bits.
module i2c_ar_lo_cmp #(
    parameter int BYTE_W = 8
) (
    input  logic [BYTE_W-1:0] byte_i,
    input  logic [BYTE_W-1:0] own_lo_i,
    output logic              lo_hit_o
);
    always_comb begin
        lo_hit_o = (byte_i == own_lo_i);
    end
endmodule

// File: rtl/i2c_addr_recog.sv
`timescale 1ns/1ps
module i2c_addr_recog
    import i2c_ar_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              byte_vld,
    input  logic              first_byte,
    input  logic [BYTE_W-1:0] byte_data,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              mode_10b,
    input  logic              gc_en,
    output logic              match_pulse,
    output logic              gcall,
    output logic              start_byte,
    output logic              rd_dir
);
    localparam int HI_W = ADDR_W - BYTE_W;

    logic hit7, hdr10, gc_hit, sb_hit, lo_hit;
    logic first_stb;
    ar_regs_t r_d, r_q;

    i2c_ar_hdr_dec #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W)) u_hdr (
        .byte_i     (byte_data),
        .own7_i     (own_addr[BYTE_W-2:0]),
        .own_hi_i   (own_addr[ADDR_W-1 -: HI_W]),
        .mode_10b_i (mode_10b),
        .gc_en_i    (gc_en),
        .hit7_o     (hit7),
        .hdr10_o    (hdr10),
        .gc_hit_o   (gc_hit),
        .sb_hit_o   (sb_hit)
    );

    i2c_ar_lo_cmp #(.BYTE_W(BYTE_W)) u_lo (
        .byte_i   (byte_data),
        .own_lo_i (own_addr[BYTE_W-1:0]),
        .lo_hit_o (lo_hit)
    );

    assign first_stb = byte_vld && first_byte;

    always_comb begin
        r_d       = r_q;
        r_d.match = 1'b0;
        if (!enable) begin
            r_d = '0;
        end else if (first_stb) begin
            r_d.rd = byte_data[0];
            r_d.gc = gc_hit;
            r_d.sb = sb_hit;
            r_d.st = ST_IDLE;
            if (gc_hit || sb_hit || hit7) begin
                r_d.match = 1'b1;
            end else if (hdr10) begin
                r_d.st = ST_WAIT_LO;
            end
        end else if (byte_vld && (r_q.st == ST_WAIT_LO)) begin
            r_d.st    = ST_IDLE;
            r_d.match = lo_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign match_pulse = r_q.match;
    assign gcall       = r_q.gc;
    assign start_byte  = r_q.sb;
    assign rd_dir      = r_q.rd;

    assert_dir_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && byte_vld && first_byte) |=> (rd_dir == $past(byte_data[0])));

    assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !(byte_vld && first_byte)) |=>
        ($stable(rd_dir) && $stable(gcall) && $stable(start_byte)));

    assert_disable_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!rd_dir && !gcall && !start_byte && !match_pulse));

    assert_flags_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({gcall, start_byte}) <= 1);

    assert_gc_needs_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(gcall) || $rose(start_byte)) |-> $past(gc_en));

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        match_pulse |=> !match_pulse);

    assert_pulse_after_byte_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_pulse) |-> $past(byte_vld));

endmodule

// File: tb/i2c_addr_recog_tb.sv
`timescale 1ns/1ps
module i2c_addr_recog_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1, byte_vld = 1'b0, first_byte = 1'b0;
    logic [7:0] byte_data = '0;
    logic [9:0] own_addr = '0;
    logic mode_10b = 1'b0, gc_en = 1'b0;
    logic match_pulse, gcall, start_byte, rd_dir;
    int total = 0, bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    i2c_addr_recog u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .byte_vld(byte_vld),
        .first_byte(first_byte), .byte_data(byte_data), .own_addr(own_addr),
        .mode_10b(mode_10b), .gc_en(gc_en), .match_pulse(match_pulse),
        .gcall(gcall), .start_byte(start_byte), .rd_dir(rd_dir)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // Strobe one byte; returns just after the capturing edge.
    task automatic send(input logic [7:0] b, input logic first);
        @(negedge clk);
        byte_vld = 1'b1; first_byte = first; byte_data = b;
        @(posedge clk); #1;
        byte_vld = 1'b0; first_byte = 1'b0;
    endtask

    task automatic idle_cycle();
        @(posedge clk); #1;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [6:0] own7s [3];
        own7s[0] = 7'h2A; own7s[1] = 7'h00; own7s[2] = 7'h7F;
        repeat (3) @(posedge clk);
        #1;
        chk("reset", "match_pulse", match_pulse, 1'b0);
        chk("reset", "gcall", gcall, 1'b0);
        chk("reset", "start_byte", start_byte, 1'b0);
        chk("reset", "rd_dir", rd_dir, 1'b0);
        rst_n = 1'b1;
        idle_cycle();

        // 7-bit sweep: R1 R4 R5 R6 R7 R10 R12
        mode_10b = 1'b0;
        for (int a = 0; a < 3; a++) begin
            own_addr = {3'b000, own7s[a]};
            for (int g = 0; g < 2; g++) begin
                gc_en = g[0];
                for (int v = 0; v < 256; v++) begin
                    logic [7:0] b;
                    logic gcx, em;
                    b   = v[7:0];
                    gcx = gc_en && (b[7:1] == 7'd0);
                    em  = gcx || ((b[7:1] != 7'd0) && (b[7:1] == own7s[a]));
                    send(b, 1'b1);
                    chk("R4/R5/R7", "match 7b", match_pulse, em);
                    chk("R6/R7", "gcall", gcall, gcx && !b[0]);
                    chk("R6/R7", "start_byte", start_byte, gcx && b[0]);
                    chk("R1", "rd_dir", rd_dir, b[0]);
                    send(v[7:0], 1'b0);
                    chk("R10 R12", "match on data byte", match_pulse, 1'b0);
                    chk("R2", "rd_dir after data byte", rd_dir, b[0]);
                end
            end
        end

        // 10-bit first-byte sweep, each followed by the right low byte: R8 R9 R6 R2
        mode_10b = 1'b1;
        own_addr = 10'h2A5;
        for (int g = 0; g < 2; g++) begin
            gc_en = g[0];
            for (int v = 0; v < 256; v++) begin
                logic [7:0] b;
                logic gcx, hdr;
                b   = v[7:0];
                gcx = gc_en && (b[7:1] == 7'd0);
                hdr = (b[7:3] == 5'b11110) && (b[2:1] == 2'b10);
                send(b, 1'b1);
                chk("R8 R6", "match after first 10b byte", match_pulse, gcx);
                chk("R6", "gcall 10b", gcall, gcx && !b[0]);
                chk("R1", "rd_dir 10b", rd_dir, b[0]);
                send(8'hA5, 1'b0);
                chk("R8 R9", "match after low byte", match_pulse, hdr);
                chk("R2", "rd_dir kept", rd_dir, b[0]);
                chk("R2", "gcall kept", gcall, gcx && !b[0]);
                idle_cycle();
                chk("R10", "pulse ended", match_pulse, 1'b0);
            end
        end

        // Low-byte sweep behind a matching header: R8 R9
        gc_en = 1'b1;
        for (int v = 0; v < 256; v++) begin
            send(8'hF4, 1'b1);
            send(v[7:0], 1'b0);
            chk("R8", "low byte compare", match_pulse, v[7:0] == 8'hA5);
            send(8'hA5, 1'b0);
            chk("R9", "ignored after low byte", match_pulse, 1'b0);
        end

        // R11: restart while header pending
        send(8'hF4, 1'b1);
        send(8'hF5, 1'b1);
        chk("R11", "no pulse on header", match_pulse, 1'b0);
        send(8'hA5, 1'b0);
        chk("R11", "restarted header matches", match_pulse, 1'b1);
        chk("R11", "rd_dir from new header", rd_dir, 1'b1);
        send(8'hF4, 1'b1);
        send(8'h00, 1'b1);
        chk("R11 R6", "general call interrupts header", match_pulse, 1'b1);
        chk("R6", "gcall set", gcall, 1'b1);
        send(8'hA5, 1'b0);
        chk("R11", "pending header abandoned", match_pulse, 1'b0);

        // R3: disable drops pending header and clears flags
        send(8'h01, 1'b1);
        chk("R6", "start byte 10b", start_byte, 1'b1);
        send(8'hF5, 1'b1);
        @(negedge clk); enable = 1'b0;
        @(posedge clk); #1;
        chk("R3", "rd_dir cleared", rd_dir, 1'b0);
        chk("R3", "start_byte cleared", start_byte, 1'b0);
        @(negedge clk); enable = 1'b1;
        send(8'hA5, 1'b0);
        chk("R3", "pending header dropped", match_pulse, 1'b0);
        @(negedge clk); enable = 1'b0;
        send(8'h00, 1'b1);
        chk("R3", "no match while disabled", match_pulse, 1'b0);
        chk("R3", "gcall stays 0 while disabled", gcall, 1'b0);
        @(negedge clk); enable = 1'b1;

        idle_cycle();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule